// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host programmed-I/O access to the local packet memory through a single data port. The host first loads a 16-bit remote address and a 16-bit remote byte count, one byte register at a time. Each data-port read or write then moves 1, 2 or 4 bytes at the current address. After the access the address moves forward by the access size and the count drops by the same amount. When the address reaches the end of the receive ring, it jumps back to the start of the ring. When the count runs out, a completion flag is raised in the interrupt status register.

The block also holds the interrupt status and mask registers. These combine the completion flag with event bits raised by neighbouring receive and transmit logic and drive one interrupt line. The packet memory itself sits outside the block, on a byte-lane request port. It returns read data one clock after a request. The engine only issues a request when the access falls inside the PROM region or inside the packet memory window. Anything outside those two regions is dropped on write and reads back as all ones.

Top module: `rdma_port_engine`

## Requirements
- R1: The host register port (write strobe `reg_we`, select `reg_sel`) loads the remote address through selects 1 (bits 7:0) and 2 (bits 15:8), and the remote count through selects 3 (bits 7:0) and 4 (bits 15:8). Each write changes only its own byte. Reading the same selects returns the current address and count.
- R2: The access size comes from `dp_w32` and from bit 0 of the configuration register (select 7). When `dp_w32` is high the access is 4 bytes. Otherwise it is 2 bytes if that bit is 1 and 1 byte if it is 0.
- R3: For 2-byte and 4-byte accesses, bit 0 of the memory byte address is cleared. Data is little-endian: the byte at the lowest address sits in bits 7:0 of the data port. On reads, lanes beyond the access size return zero.
- R4: After each access the address increases by the access size. If the result equals the ring stop page (select 6) times 256, the address is reloaded with the ring first page (select 5) times 256.
- R5: If the count before an access is less than or equal to the access size, the count becomes zero and status bit 6 is set on the next clock edge. Otherwise the count is reduced by the access size.
- R6: A write to the command register (select 0) sets status bit 6 immediately when all of these hold: bit 0 of the written value is 0, bit 3 or bit 4 is 1, and the count is zero. Any command write with bit 0 equal to 0 clears status bit 7.
- R7: `irq` is high exactly when status AND mask (select 9) AND 0x7F is non-zero. Status bit 7 never raises `irq`.
- R8: Writing the status register (select 8) clears each of bits 6:0 that is written as 1 and leaves bit 7 unchanged. A pulse on `ev_set[k]` sets status bit k, for k from 0 to 5.
- R9: An access is inside the window when its aligned address is below PROM_BYTES, or when it lies at or above PMEM_BASE and its last byte is below MEM_BYTES. Outside the window a write leaves memory unchanged and a read returns all ones in the access width. In both cases the address and count still advance.
- R10: `dp_rvalid` is high exactly one cycle after a cycle with `dp_rd` high, and `dp_rdata` is valid in that cycle.
- R11: After reset the address, count and mask read as zero, the status reads 0x80, and `irq` and `dp_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 4 | Host register select |
| reg_wdata | input | 8 | Host register write data |
| reg_rdata | output | 8 | Host register read data (combinational from `reg_sel`) |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wr | input | 1 | Data-port write strobe |
| dp_w32 | input | 1 | Requests a 4-byte access |
| dp_wdata | input | 32 | Data-port write data, little-endian |
| dp_rdata | output | 32 | Data-port read data |
| dp_rvalid | output | 1 | Read data valid, one cycle after `dp_rd` |
| ev_set | input | 6 | Status event pulses from neighbouring logic |
| irq | output | 1 | Interrupt line |
| mem_req | output | 1 | Memory request (only issued inside the window) |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_lanes | output | 4 | Byte lanes taking part in the access |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |

## Verification
The hardest cases to reach are those where several boundaries meet in one access:
- a wide access from an odd address that steps past the ring stop without ever equalling it, and so walks off the top of memory;
- a 4-byte access that straddles the end of the PROM region or the end of memory.

The bench gets there by sweeping every access width over start addresses placed just below those edges: the PROM top, the gap below the packet window, the last bytes before the ring stop page, and odd addresses next to each of them. For each access it computes the expected aligned address, window decision, data, next address and remaining count, then checks them through the data port and the register readback.

// File: rtl/rdma_pkg.sv
`timescale 1ns/1ps
package rdma_pkg;

   typedef enum logic [1:0] {
      XS_BYTE = 2'd0,
      XS_HALF = 2'd1,
      XS_WORD = 2'd2
   } xfer_size_e;

   localparam logic [3:0] RS_CMD        = 4'd0;
   localparam logic [3:0] RS_ADDR_LO    = 4'd1;
   localparam logic [3:0] RS_ADDR_HI    = 4'd2;
   localparam logic [3:0] RS_CNT_LO     = 4'd3;
   localparam logic [3:0] RS_CNT_HI     = 4'd4;
   localparam logic [3:0] RS_RING_FIRST = 4'd5;
   localparam logic [3:0] RS_RING_STOP  = 4'd6;
   localparam logic [3:0] RS_CFG        = 4'd7;
   localparam logic [3:0] RS_STATUS     = 4'd8;
   localparam logic [3:0] RS_MASK       = 4'd9;

   localparam int ST_DMA_DONE = 6;
   localparam int ST_RESET    = 7;

   function automatic logic [2:0] xs_bytes(xfer_size_e s);
      case (s)
         XS_HALF: return 3'd2;
         XS_WORD: return 3'd4;
         default: return 3'd1;
      endcase
   endfunction

   function automatic logic [3:0] xs_lanes(xfer_size_e s);
      case (s)
         XS_HALF: return 4'b0011;
         XS_WORD: return 4'b1111;
         default: return 4'b0001;
      endcase
   endfunction

   function automatic logic [31:0] lane_bits(logic [3:0] lanes);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{lanes[i]}};
      return m;
   endfunction

endpackage

// File: rtl/rdma_addr_cnt.sv
`timescale 1ns/1ps
module rdma_addr_cnt #(
   parameter int AW  = 16,
   parameter int CW  = 16,
   parameter int PGW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld_alo,
   input  logic           ld_ahi,
   input  logic           ld_clo,
   input  logic           ld_chi,
   input  logic [7:0]     ld_byte,
   input  logic           step,
   input  logic [2:0]     step_bytes,
   input  logic [PGW-1:0] first_pg,
   input  logic [PGW-1:0] stop_pg,
   output logic [AW-1:0]  addr_q,
   output logic [CW-1:0]  cnt_q,
   output logic           done_pulse
);
   localparam int PG_SHIFT = 8;

   logic [AW-1:0] first_addr, stop_addr, addr_inc, addr_nxt;
   logic [CW-1:0] cnt_nxt;
   logic          last_beat;

   assign first_addr = AW'(first_pg) << PG_SHIFT;
   assign stop_addr  = AW'(stop_pg) << PG_SHIFT;
   assign addr_inc   = addr_q + AW'(step_bytes);
   assign last_beat  = cnt_q <= CW'(step_bytes);
   assign done_pulse = step && last_beat;

   always_comb begin
      addr_nxt = addr_q;
      cnt_nxt  = cnt_q;
      if (step) begin
         addr_nxt = (addr_inc == stop_addr) ? first_addr : addr_inc;
         cnt_nxt  = last_beat ? '0 : cnt_q - CW'(step_bytes);
      end
      if (ld_alo) addr_nxt[7:0]    = ld_byte;
      if (ld_ahi) addr_nxt[AW-1:8] = ld_byte[AW-9:0];
      if (ld_clo) cnt_nxt[7:0]     = ld_byte;
      if (ld_chi) cnt_nxt[CW-1:8]  = ld_byte[CW-9:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else begin
         addr_q <= addr_nxt;
         cnt_q  <= cnt_nxt;
      end
   end

   assert_cnt_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld_clo && !ld_chi) |=> (cnt_q < $past(cnt_q) || cnt_q == '0));

   assert_no_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld_alo && !ld_ahi && first_pg != stop_pg) |=> addr_q != $past(stop_addr));

endmodule

// File: rtl/rdma_window.sv
`timescale 1ns/1ps
module rdma_window
   import rdma_pkg::*;
#(
   parameter int AW         = 16,
   parameter int MEM_BYTES  = 32768,
   parameter int PMEM_BASE  = 16384,
   parameter int PROM_BYTES = 32,
   parameter bit ALLOW_W32  = 1'b1
) (
   input  logic [AW-1:0] base_addr,
   input  logic          wide_cfg,
   input  logic          want_w32,
   output xfer_size_e    xsz,
   output logic [2:0]    nbytes,
   output logic [3:0]    lanes,
   output logic [AW-1:0] acc_addr,
   output logic          in_win
);
   localparam logic [AW:0] PROM_LIM = (AW+1)'(PROM_BYTES);
   localparam logic [AW:0] BASE_LIM = (AW+1)'(PMEM_BASE);
   localparam logic [AW:0] MEM_LIM  = (AW+1)'(MEM_BYTES);

   generate
      if (ALLOW_W32) begin : g_w32
         assign xsz = want_w32 ? XS_WORD : (wide_cfg ? XS_HALF : XS_BYTE);
      end else begin : g_w16
         logic unused_w32;
         assign unused_w32 = want_w32;
         assign xsz = wide_cfg ? XS_HALF : XS_BYTE;
      end
   endgenerate

   logic [AW:0] ext_addr, end_addr;

   assign nbytes   = xs_bytes(xsz);
   assign lanes    = xs_lanes(xsz);
   assign acc_addr = (xsz == XS_BYTE) ? base_addr : {base_addr[AW-1:1], 1'b0};
   assign ext_addr = {1'b0, acc_addr};
   assign end_addr = ext_addr + (AW+1)'(nbytes);
   assign in_win   = (ext_addr < PROM_LIM) ||
                     (ext_addr >= BASE_LIM && end_addr <= MEM_LIM);

endmodule

// File: rtl/rdma_irq_ctl.sv
`timescale 1ns/1ps
module rdma_irq_ctl
   import rdma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [5:0] ev_set,
   input  logic       dma_done,
   input  logic       cmd_wr,
   input  logic [7:0] cmd_byte,
   input  logic       cnt_zero,
   input  logic       st_wr,
   input  logic [7:0] st_wdata,
   input  logic       mk_wr,
   input  logic [7:0] mk_wdata,
   output logic [7:0] status_q,
   output logic [7:0] mask_q,
   output logic       irq
);
   logic [7:0] status_nxt;
   logic       running_cmd, zero_len_cmd;

   assign running_cmd  = cmd_wr && !cmd_byte[0];
   assign zero_len_cmd = running_cmd && (cmd_byte[3] || cmd_byte[4]) && cnt_zero;

   always_comb begin
      status_nxt = status_q;
      if (st_wr) status_nxt[6:0] = status_q[6:0] & ~st_wdata[6:0];
      if (running_cmd) status_nxt[ST_RESET] = 1'b0;
      status_nxt[5:0] = status_nxt[5:0] | ev_set;
      if (dma_done || zero_len_cmd) status_nxt[ST_DMA_DONE] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 8'h80;
         mask_q   <= 8'h00;
      end else begin
         status_q <= status_nxt;
         if (mk_wr) mask_q <= mk_wdata;
      end
   end

   assign irq = |(status_q[6:0] & mask_q[6:0]);

   assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done |=> status_q[ST_DMA_DONE]);

   assert_reset_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(status_q[ST_RESET]));

endmodule

// File: rtl/rdma_port_engine.sv
`timescale 1ns/1ps
module rdma_port_engine
   import rdma_pkg::*;
#(
   parameter int AW         = 16,
   parameter int CW         = 16,
   parameter int PGW        = 8,
   parameter int MEM_BYTES  = 32768,
   parameter int PMEM_BASE  = 16384,
   parameter int PROM_BYTES = 32,
   parameter bit ALLOW_W32  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [3:0]    reg_sel,
   input  logic [7:0]    reg_wdata,
   output logic [7:0]    reg_rdata,
   input  logic          dp_rd,
   input  logic          dp_wr,
   input  logic          dp_w32,
   input  logic [31:0]   dp_wdata,
   output logic [31:0]   dp_rdata,
   output logic          dp_rvalid,
   input  logic [5:0]    ev_set,
   output logic          irq,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [3:0]    mem_lanes,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata
);
   localparam logic [AW-1:0] PROM_TOP  = AW'(PROM_BYTES);
   localparam logic [AW-1:0] PMEM_LOW  = AW'(PMEM_BASE);

   generate
      if (AW < 9 || AW > 16) begin : g_bad_aw
         $error("rdma_port_engine: AW must lie in 9..16");
      end
      if (CW < 9 || CW > 16) begin : g_bad_cw
         $error("rdma_port_engine: CW must lie in 9..16");
      end
      if (PGW + 8 > AW || PGW > 8) begin : g_bad_pgw
         $error("rdma_port_engine: ring page field does not fit the address");
      end
      if (MEM_BYTES > (1 << AW) || PMEM_BASE > MEM_BYTES || PROM_BYTES > PMEM_BASE) begin : g_bad_map
         $error("rdma_port_engine: inconsistent memory map");
      end
   endgenerate

   logic [7:0]     cmd_q;
   logic [PGW-1:0] first_pg_q, stop_pg_q;
   logic           cfg_wide_q;

   logic           wr_cmd, wr_first, wr_stop, wr_cfg, wr_status, wr_mask;
   logic           access, dma_done;
   logic [AW-1:0]  addr_q, acc_addr;
   logic [CW-1:0]  cnt_q;
   logic [2:0]     nbytes;
   logic [3:0]     lanes;
   logic           in_win;
   xfer_size_e     xsz;
   logic [7:0]     status_q, mask_q;

   logic           rd_pend_q, rd_hit_q;
   logic [3:0]     rd_lanes_q;

   assign wr_cmd    = reg_we && reg_sel == RS_CMD;
   assign wr_first  = reg_we && reg_sel == RS_RING_FIRST;
   assign wr_stop   = reg_we && reg_sel == RS_RING_STOP;
   assign wr_cfg    = reg_we && reg_sel == RS_CFG;
   assign wr_status = reg_we && reg_sel == RS_STATUS;
   assign wr_mask   = reg_we && reg_sel == RS_MASK;
   assign access    = dp_rd || dp_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q      <= 8'h01;
         first_pg_q <= '0;
         stop_pg_q  <= '0;
         cfg_wide_q <= 1'b0;
      end else begin
         if (wr_cmd)   cmd_q      <= reg_wdata;
         if (wr_first) first_pg_q <= reg_wdata[PGW-1:0];
         if (wr_stop)  stop_pg_q  <= reg_wdata[PGW-1:0];
         if (wr_cfg)   cfg_wide_q <= reg_wdata[0];
      end
   end

   rdma_window #(
      .AW(AW), .MEM_BYTES(MEM_BYTES), .PMEM_BASE(PMEM_BASE),
      .PROM_BYTES(PROM_BYTES), .ALLOW_W32(ALLOW_W32)
   ) u_window (
      .base_addr(addr_q), .wide_cfg(cfg_wide_q), .want_w32(dp_w32),
      .xsz(xsz), .nbytes(nbytes), .lanes(lanes),
      .acc_addr(acc_addr), .in_win(in_win)
   );

   rdma_addr_cnt #(.AW(AW), .CW(CW), .PGW(PGW)) u_addr_cnt (
      .clk(clk), .rst_n(rst_n),
      .ld_alo(reg_we && reg_sel == RS_ADDR_LO),
      .ld_ahi(reg_we && reg_sel == RS_ADDR_HI),
      .ld_clo(reg_we && reg_sel == RS_CNT_LO),
      .ld_chi(reg_we && reg_sel == RS_CNT_HI),
      .ld_byte(reg_wdata),
      .step(access), .step_bytes(nbytes),
      .first_pg(first_pg_q), .stop_pg(stop_pg_q),
      .addr_q(addr_q), .cnt_q(cnt_q), .done_pulse(dma_done)
   );

   rdma_irq_ctl u_irq (
      .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .dma_done(dma_done),
      .cmd_wr(wr_cmd), .cmd_byte(reg_wdata), .cnt_zero(cnt_q == '0),
      .st_wr(wr_status), .st_wdata(reg_wdata),
      .mk_wr(wr_mask), .mk_wdata(reg_wdata),
      .status_q(status_q), .mask_q(mask_q), .irq(irq)
   );

   assign mem_req   = access && in_win;
   assign mem_we    = dp_wr;
   assign mem_addr  = acc_addr;
   assign mem_lanes = lanes;
   assign mem_wdata = dp_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend_q  <= 1'b0;
         rd_hit_q   <= 1'b0;
         rd_lanes_q <= 4'b0001;
      end else begin
         rd_pend_q <= dp_rd;
         if (dp_rd) begin
            rd_hit_q   <= in_win;
            rd_lanes_q <= lanes;
         end
      end
   end

   assign dp_rvalid = rd_pend_q;
   assign dp_rdata  = rd_hit_q ? (mem_rdata & lane_bits(rd_lanes_q)) : lane_bits(rd_lanes_q);

   always_comb begin
      case (reg_sel)
         RS_CMD:        reg_rdata = cmd_q;
         RS_ADDR_LO:    reg_rdata = addr_q[7:0];
         RS_ADDR_HI:    reg_rdata = 8'(addr_q >> 8);
         RS_CNT_LO:     reg_rdata = cnt_q[7:0];
         RS_CNT_HI:     reg_rdata = 8'(cnt_q >> 8);
         RS_RING_FIRST: reg_rdata = 8'(first_pg_q);
         RS_RING_STOP:  reg_rdata = 8'(stop_pg_q);
         RS_CFG:        reg_rdata = {7'd0, cfg_wide_q};
         RS_STATUS:     reg_rdata = status_q;
         RS_MASK:       reg_rdata = mask_q;
         default:       reg_rdata = 8'h00;
      endcase
   end

   assert_rvalid_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dp_rvalid |-> $past(dp_rd));

   assert_one_port_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(dp_rd && dp_wr));

   assert_win_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr < PROM_TOP || mem_addr >= PMEM_LOW));

   assert_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_lanes[1]) |-> !mem_addr[0]);

endmodule

// File: tb/rdma_port_engine_test.sv
`timescale 1ns/1ps
module rdma_port_engine_test;

   localparam int MEMB  = 1024;
   localparam int PMB   = 512;
   localparam int PRB   = 32;
   localparam int FPG   = 2;
   localparam int SPG   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_sel = 4'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        dp_rd = 1'b0, dp_wr = 1'b0, dp_w32 = 1'b0;
   logic [31:0] dp_wdata = 32'd0;
   logic [31:0] dp_rdata;
   logic        dp_rvalid;
   logic [5:0]  ev_set = 6'd0;
   logic        irq;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [3:0]  mem_lanes;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = 32'd0;

   always #5 clk = ~clk;

   rdma_port_engine #(
      .AW(16), .CW(16), .PGW(8), .MEM_BYTES(MEMB), .PMEM_BASE(PMB),
      .PROM_BYTES(PRB), .ALLOW_W32(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_rd(dp_rd),
      .dp_wr(dp_wr), .dp_w32(dp_w32), .dp_wdata(dp_wdata),
      .dp_rdata(dp_rdata), .dp_rvalid(dp_rvalid), .ev_set(ev_set),
      .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_lanes(mem_lanes), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   logic [7:0] mem [0:MEMB-1];

   always @(posedge clk) begin
      if (mem_req) begin
         for (int i = 0; i < 4; i++) begin
            if (mem_we) begin
               if (mem_lanes[i] && int'(mem_addr) + i < MEMB)
                  mem[int'(mem_addr) + i] <= mem_wdata[8*i +: 8];
            end else begin
               mem_rdata[8*i +: 8] <= (int'(mem_addr) + i < MEMB) ? mem[int'(mem_addr) + i] : 8'h00;
            end
         end
      end
   end

   int n_cmp = 0;
   int n_bad = 0;
   int m_addr, m_cnt;
   bit m_done;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [3:0] sel, input logic [7:0] val);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rreg(input logic [3:0] sel, output logic [7:0] val);
      @(negedge clk);
      reg_sel = sel;
      #1 val = reg_rdata;
   endtask

   task automatic load(input int a, input int c);
      wreg(4'd1, 8'(a));
      wreg(4'd2, 8'(a >> 8));
      wreg(4'd3, 8'(c));
      wreg(4'd4, 8'(c >> 8));
   endtask

   task automatic read_ac(output int a, output int c);
      logic [7:0] lo, hi;
      rreg(4'd1, lo); rreg(4'd2, hi); a = {16'd0, hi, lo};
      rreg(4'd3, lo); rreg(4'd4, hi); c = {16'd0, hi, lo};
   endtask

   task automatic dp_read(input bit w32, output logic [31:0] d, output bit v);
      @(negedge clk);
      dp_rd = 1'b1; dp_w32 = w32;
      @(negedge clk);
      dp_rd = 1'b0; dp_w32 = 1'b0;
      v = dp_rvalid; d = dp_rdata;
   endtask

   task automatic dp_write(input bit w32, input logic [31:0] d);
      @(negedge clk);
      dp_wr = 1'b1; dp_w32 = w32; dp_wdata = d;
      @(negedge clk);
      dp_wr = 1'b0; dp_w32 = 1'b0;
   endtask

   task automatic pulse_ev(input logic [5:0] p);
      @(negedge clk);
      ev_set = p;
      @(negedge clk);
      ev_set = 6'd0;
   endtask

   function automatic int xbytes(bit wide, bit w32);
      return w32 ? 4 : (wide ? 2 : 1);
   endfunction

   function automatic bit inwin(int a, int n);
      return (a < PRB) || (a >= PMB && a + n <= MEMB);
   endfunction

   function automatic logic [31:0] exp_read(int a, int n);
      logic [31:0] r;
      int al;
      al = (n > 1) ? (a & ~1) : a;
      r = 32'd0;
      if (!inwin(al, n)) return (n == 4) ? 32'hFFFF_FFFF : (n == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
      for (int i = 0; i < n; i++) r[8*i +: 8] = (al + i < MEMB) ? mem[al + i] : 8'h00;
      return r;
   endfunction

   task automatic advance(input int n);
      m_done = (m_cnt <= n);
      m_cnt  = m_done ? 0 : m_cnt - n;
      m_addr = (m_addr + n) & 16'hFFFF;
      if (m_addr == SPG * 256) m_addr = FPG * 256;
   endtask

   initial begin : watchdog
      #1_500_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0]  v8;
      logic [31:0] d;
      bit          vld;
      int          a, c, n;
      bit          sticky;
      int          starts [6];
      logic [7:0]  st;

      starts = '{0, 30, 'h1FD, 'h2FF, 'h3F9, 'h3FF};
      for (int i = 0; i < MEMB; i++) mem[i] = 8'(i * 37 + 11);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      read_ac(a, c);
      chk("R11 addr after reset", 32'(a), 32'd0);
      chk("R11 count after reset", 32'(c), 32'd0);
      rreg(4'd8, v8); chk("R11 status after reset", 32'(v8), 32'h80);
      rreg(4'd9, v8); chk("R11 mask after reset", 32'(v8), 32'h00);
      chk("R11 irq after reset", 32'(irq), 32'd0);
      chk("R11 rvalid after reset", 32'(dp_rvalid), 32'd0);

      // R7: status bit 7 never raises irq, over every mask value
      for (int m = 0; m < 256; m++) begin
         wreg(4'd9, 8'(m));
         chk("R7 reset flag masked", 32'(irq), 32'd0);
      end

      // R8: clear write leaves bit 7
      wreg(4'd8, 8'hFF);
      rreg(4'd8, v8); chk("R8 bit7 survives clear", 32'(v8), 32'h80);

      // R1: byte-wise loads and readback
      load('h1234, 'hABCD);
      read_ac(a, c);
      chk("R1 address load", 32'(a), 32'h1234);
      chk("R1 count load", 32'(c), 32'hABCD);
      wreg(4'd2, 8'h56);
      wreg(4'd3, 8'h01);
      read_ac(a, c);
      chk("R1 high address byte only", 32'(a), 32'h5634);
      chk("R1 low count byte only", 32'(c), 32'hAB01);

      // R6: command handling
      load(0, 0);
      wreg(4'd0, 8'h22);
      rreg(4'd8, v8); chk("R6 start clears bit7, no rd/wr", 32'(v8), 32'h00);
      wreg(4'd0, 8'h0B);
      rreg(4'd8, v8); chk("R6 stop bit blocks zero-length done", 32'(v8), 32'h00);
      wreg(4'd0, 8'h0A);
      rreg(4'd8, v8); chk("R6 zero-length read done", 32'(v8), 32'h40);
      wreg(4'd8, 8'h40);
      wreg(4'd0, 8'h12);
      rreg(4'd8, v8); chk("R6 zero-length write done", 32'(v8), 32'h40);
      wreg(4'd8, 8'h40);
      wreg(4'd3, 8'd3);
      wreg(4'd0, 8'h12);
      rreg(4'd8, v8); chk("R6 nonzero count no done", 32'(v8), 32'h00);

      // R7/R8: events and mask sweep
      foreach (starts[k]) begin end
      for (int pi = 0; pi < 9; pi++) begin
         logic [5:0] p;
         p = (pi < 6) ? 6'(1 << pi) : (pi == 6) ? 6'h15 : (pi == 7) ? 6'h2A : 6'h3F;
         wreg(4'd8, 8'h7F);
         pulse_ev(p);
         if (pi == 8) begin
            wreg(4'd3, 8'd0);
            wreg(4'd0, 8'h0A);
         end
         st = (pi == 8) ? 8'h7F : {2'b00, p};
         rreg(4'd8, v8); chk("R8 event sets status", 32'(v8), 32'(st));
         for (int m = 0; m < 256; m++) begin
            wreg(4'd9, 8'(m));
            chk("R7 irq vs status and mask", 32'(irq), 32'((st & 8'(m) & 8'h7F) != 8'h00));
         end
      end
      wreg(4'd8, 8'h15);
      rreg(4'd8, v8); chk("R8 partial clear", 32'(v8), 32'h6A);
      wreg(4'd9, 8'h00);

      // Ring setup
      wreg(4'd5, 8'(FPG));
      wreg(4'd6, 8'(SPG));

      // R2 R3 R4 R5 R9 R10: read sweep over widths and edge starts
      for (int mode = 0; mode < 3; mode++) begin
         bit wide, w32;
         wide = (mode == 1);
         w32  = (mode == 2);
         n = xbytes(wide, w32);
         wreg(4'd7, 8'(wide));
         foreach (starts[si]) begin
            load(starts[si], 9);
            wreg(4'd8, 8'h40);
            m_addr = starts[si]; m_cnt = 9; sticky = 0;
            for (int s = 0; s < 5; s++) begin
               logic [31:0] e;
               e = exp_read(m_addr, n);
               dp_read(w32, d, vld);
               chk("R10 rvalid one cycle after read", 32'(vld), 32'd1);
               chk("R2 R3 R9 read data", d, e);
               advance(n);
               sticky = sticky | m_done;
               read_ac(a, c);
               chk("R4 next address", 32'(a), 32'(m_addr));
               chk("R5 remaining count", 32'(c), 32'(m_cnt));
               rreg(4'd8, v8);
               chk("R5 completion flag", 32'(v8[6]), 32'(sticky));
            end
         end
      end

      // R3: little-endian 16-bit writes from an odd address
      wreg(4'd7, 8'd1);
      load('h301, 4);
      dp_write(1'b0, 32'h0000BEEF);
      chk("R3 half write low byte", 32'(mem['h300]), 32'hEF);
      chk("R3 half write high byte", 32'(mem['h301]), 32'hBE);
      dp_write(1'b0, 32'h0000CAFE);
      chk("R3 second half write", {16'd0, mem['h303], mem['h302]}, 32'h0000CAFE);
      read_ac(a, c);
      chk("R5 count after two halves", 32'(c), 32'd0);
      chk("R4 address after two halves", 32'(a), 32'h305);

      // R2: 32-bit write overrides the config bit
      wreg(4'd7, 8'd0);
      load('h210, 8);
      dp_write(1'b1, 32'h11223344);
      chk("R2 word write", {mem['h213], mem['h212], mem['h211], mem['h210]}, 32'h11223344);

      // R4: byte write at the ring end wraps
      load('h3FF, 5);
      dp_write(1'b0, 32'h5A);
      chk("R4 byte write stored", 32'(mem['h3FF]), 32'h5A);
      read_ac(a, c);
      chk("R4 wrap to ring start", 32'(a), 32'h200);

      // R9: writes outside the window are dropped but still advance
      load('h100, 2);
      dp_write(1'b0, 32'h77);
      chk("R9 hole write ignored", 32'(mem['h100]), 32'(8'('h100 * 37 + 11)));
      read_ac(a, c);
      chk("R9 address advances in hole", 32'(a), 32'h101);
      chk("R9 count drops in hole", 32'(c), 32'd1);
      st = mem['h3FE];
      load('h3FF, 8);
      dp_write(1'b1, 32'hDEADBEEF);
      chk("R9 word past memory end ignored", 32'(mem['h3FE]), 32'(st));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule